// File: doc/BRIEF.md
# Character parity generator and checker

This block sits in the character path of a byte-oriented synchronous serial channel. On the way out it takes one data byte at a time and emits a 9-bit word: the byte in bits 7..0 and a parity bit in bit 8. On the way in it takes a 9-bit word, returns the byte and raises an error flag when the parity bit does not match what the receive mode expects. Each direction has its own 2-bit mode: odd, even, forced 0 and forced 1. The mode may change between characters. A single enable turns parity handling on. The enable is meant to be driven high only while the block check in use is a longitudinal redundancy check. While it is low, bit 8 is sent as 0 and no error is ever raised.

All four data interfaces are valid/ready streams. A word moves when valid and ready are both high at a rising clock edge. Each direction holds one registered output stage. Its input ready is high whenever that stage is empty or is being drained in the same cycle. While an output is valid and its ready is low, the output word, byte and error flag are held unchanged. A source must hold its valid and data until it sees ready.

An optional receive gate stops the node from hearing its own transmission on a shared line. When the gate option is on and the local request-to-send is high, each incoming word is still accepted but is discarded and produces no output. Serialisation, sync detection and block-check accumulation belong to neighbouring blocks.

Top module: `parity_char_unit`

## Requirements
- R1: A synchronous active-high reset forces `tx_out_valid`, `rx_out_valid`, `rx_out_err`, `tx_out_word` and `rx_out_data` to zero on the next clock edge.
- R2: With `par_en` high and transmit mode 2'b00 (odd), the accepted byte plus bit 8 of `tx_out_word` hold an odd number of ones.
- R3: With `par_en` high and transmit mode 2'b10 (even), the 9-bit `tx_out_word` holds an even number of ones.
- R4: With `par_en` high, transmit mode 2'b01 sends bit 8 as 0 and transmit mode 2'b11 sends bit 8 as 1, whatever the data.
- R5: With `par_en` low, both mode fields are ignored: bit 8 of `tx_out_word` is 0 and `rx_out_err` is 0 for every character.
- R6: With `par_en` high, `rx_out_err` is 1 exactly when the received 9-bit word has an even count of ones in mode 2'b00 (odd), or an odd count in mode 2'b10 (even).
- R7: With `par_en` high, `rx_out_err` is 1 exactly when received bit 8 is not 0 in mode 2'b01, or not 1 in mode 2'b11.
- R8: The mode fields and `par_en` are sampled in the cycle a character is accepted. Later changes do not alter a character already held at the output.
- R9: Each input ready equals "output stage empty or output ready high". A valid output with its ready low stays valid and unchanged.
- R10: With `rx_gate_en` and `rts` both high, an accepted receive word is dropped with no output. With `rx_gate_en` low, reception goes on regardless of `rts`.
- R11: The data byte passes unchanged: `tx_out_word[7:0]` is the accepted byte and `rx_out_data` is bits 7..0 of the accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| par_en | input | 1 | Parity handling enable (high only for longitudinal block check) |
| tx_mode | input | 2 | Transmit parity mode: 00 odd, 01 low, 10 even, 11 high |
| rx_mode | input | 2 | Receive parity mode, same encoding |
| rx_gate_en | input | 1 | Discard reception while request-to-send is high |
| rts | input | 1 | Local request-to-send |
| tx_in_valid | input | 1 | Transmit byte valid |
| tx_in_ready | output | 1 | Transmit byte accepted |
| tx_in_data | input | 8 | Transmit byte |
| tx_out_valid | output | 1 | Transmit word valid |
| tx_out_ready | input | 1 | Downstream takes transmit word |
| tx_out_word | output | 9 | Byte with parity in bit 8 |
| rx_in_valid | input | 1 | Received word valid |
| rx_in_ready | output | 1 | Received word accepted |
| rx_in_word | input | 9 | Received byte with parity bit 8 |
| rx_out_valid | output | 1 | Received byte valid |
| rx_out_ready | input | 1 | Downstream takes received byte |
| rx_out_data | output | 8 | Received byte |
| rx_out_err | output | 1 | Parity error for this byte |

## Verification
The hardest case to reach is a held character whose mode or enable changes while it is stalled. The stimulus must accept a character and keep downstream ready low for several cycles while the mode inputs move, and only then drain it. The bench runs phases with low output-ready probability and draws new modes on every cycle. Its reference model latches the mode only at acceptance. It also toggles request-to-send while the gate is on, so dropped words fall both into an empty stage and into a stage being drained.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    PM_ODD  = 2'b00,
    PM_LOW  = 2'b01,
    PM_EVEN = 2'b10,
    PM_HIGH = 2'b11
  } par_mode_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pcu_tx_stage.sv
module pcu_tx_stage
  import pcu_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          par_en,
  input  logic [1:0]    mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW:0]   out_word
);
  logic par_bit;
  logic take;

  // parity bit for the byte now on the input, under the mode now applied
  always_comb begin
    par_bit = 1'b0;
    if (par_en) begin
      case (par_mode_e'(mode))
        PM_ODD:  par_bit = ~(^in_data);
        PM_EVEN: par_bit = ^in_data;
        PM_LOW:  par_bit = 1'b0;
        PM_HIGH: par_bit = 1'b1;
        default: par_bit = 1'b0;
      endcase
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_word  <= {par_bit, in_data};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_odd_total_r2: assert property (@(posedge clk) disable iff (rst)
    (take && par_en && mode == 2'b00) |=> (^out_word) == 1'b1);

  p_even_total_r3: assert property (@(posedge clk) disable iff (rst)
    (take && par_en && mode == 2'b10) |=> (^out_word) == 1'b0);

  p_forced_r4: assert property (@(posedge clk) disable iff (rst)
    (take && par_en && mode[0]) |=> out_word[DW] == $past(mode[1]));

  p_off_r5: assert property (@(posedge clk) disable iff (rst)
    (take && !par_en) |=> !out_word[DW]);

  p_hold_tx_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
endmodule

// File: rtl/pcu_rx_stage.sv
module pcu_rx_stage
  import pcu_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          par_en,
  input  logic [1:0]    mode,
  input  logic          gate_en,
  input  logic          rts,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW:0]   in_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_err
);
  logic bad;
  logic odd_ones;
  logic take;
  logic muted;

  assign odd_ones = ^in_word;

  always_comb begin
    bad = 1'b0;
    if (par_en) begin
      case (par_mode_e'(mode))
        PM_ODD:  bad = !odd_ones;
        PM_EVEN: bad = odd_ones;
        PM_LOW:  bad = in_word[DW];
        PM_HIGH: bad = !in_word[DW];
        default: bad = 1'b0;
      endcase
    end
  end

  assign muted    = gate_en && rts;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else if (take && !muted) begin
      out_valid <= 1'b1;
      out_data  <= in_word[DW-1:0];
      out_err   <= bad;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_low_high_r7: assert property (@(posedge clk) disable iff (rst)
    (take && !muted && par_en && mode[0]) |=> out_err == ($past(in_word[DW]) != $past(mode[1])));

  p_err_off_r5: assert property (@(posedge clk) disable iff (rst)
    (take && !muted && !par_en) |=> !out_err);

  p_gate_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (take && muted) |=> !out_valid);

  p_hold_rx_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));
endmodule

// File: rtl/parity_char_unit.sv
module parity_char_unit
  import pcu_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          par_en,
  input  logic [1:0]    tx_mode,
  input  logic [1:0]    rx_mode,
  input  logic          rx_gate_en,
  input  logic          rts,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW:0]   tx_out_word,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW:0]   rx_in_word,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  output logic          rx_out_err
);
  pcu_tx_stage #(.DW(DW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .par_en   (par_en),
    .mode     (tx_mode),
    .in_valid (tx_in_valid),
    .in_ready (tx_in_ready),
    .in_data  (tx_in_data),
    .out_valid(tx_out_valid),
    .out_ready(tx_out_ready),
    .out_word (tx_out_word)
  );

  pcu_rx_stage #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .par_en   (par_en),
    .mode     (rx_mode),
    .gate_en  (rx_gate_en),
    .rts      (rts),
    .in_valid (rx_in_valid),
    .in_ready (rx_in_ready),
    .in_word  (rx_in_word),
    .out_valid(rx_out_valid),
    .out_ready(rx_out_ready),
    .out_data (rx_out_data),
    .out_err  (rx_out_err)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!tx_out_valid && !rx_out_valid && !rx_out_err));
endmodule

// File: tb/sim_parity_char_unit.sv
module sim_parity_char_unit;
  localparam time PERIOD = 10ns;
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_en = 1'b0;
  logic [1:0] tx_mode = 2'b00, rx_mode = 2'b00;
  logic rx_gate_en = 1'b0, rts = 1'b0;
  logic tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic [8:0] rx_in_word = '0;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid, rx_out_err;
  logic [8:0] tx_out_word;
  logic [7:0] rx_out_data;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  bit       m_tv = 0, m_rv = 0, m_after_rst = 0;
  bit [8:0] m_tw = 0;
  bit [7:0] m_rd = 0;
  bit       m_re = 0;
  string    m_ttag = "R2", m_rtag = "R6";
  int       m_thold = 0;
  int       m_tq[$];

  parity_char_unit u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic int ones(input bit [8:0] w);
    int c = 0;
    for (int i = 0; i < 9; i++) if (w[i]) c++;
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    if (m_after_rst) begin
      chk(!tx_out_valid && !rx_out_valid && !rx_out_err && tx_out_word == 0 && rx_out_data == 0,
          "R1", "outputs after reset",
          {tx_out_valid, rx_out_valid, rx_out_err, tx_out_word, rx_out_data}, 0);
    end
    chk(tx_out_valid == m_tv, "R9", "tx_out_valid", tx_out_valid, m_tv);
    chk(rx_out_valid == m_rv, (m_rtag == "R10") ? "R10" : "R9", "rx_out_valid", rx_out_valid, m_rv);
    chk(tx_in_ready == (!m_tv || tx_out_ready), "R9", "tx_in_ready", tx_in_ready, !m_tv || tx_out_ready);
    chk(rx_in_ready == (!m_rv || rx_out_ready), "R9", "rx_in_ready", rx_in_ready, !m_rv || rx_out_ready);
    if (m_tv) begin
      chk(tx_out_word[7:0] == m_tw[7:0], "R11", "tx byte", tx_out_word[7:0], m_tw[7:0]);
      chk(tx_out_word[8] == m_tw[8], (m_thold > 0) ? "R8" : m_ttag, "tx parity bit",
          tx_out_word[8], m_tw[8]);
      if (m_tq.size() > 0)
        chk(tx_out_word == m_tq[0], "R9", "tx queue head", tx_out_word, m_tq[0]);
    end
    if (m_rv) begin
      chk(rx_out_data == m_rd, "R11", "rx byte", rx_out_data, m_rd);
      chk(rx_out_err == m_re, m_rtag, "rx error", rx_out_err, m_re);
    end
  endtask

  task automatic model_update();
    bit tfire, rfire;
    bit [8:0] w;
    int c;
    if (rst) begin
      m_tv = 0; m_rv = 0; m_tq.delete(); m_thold = 0; m_after_rst = 1;
      return;
    end
    m_after_rst = 0;
    tfire = tx_in_valid && (!m_tv || tx_out_ready);
    rfire = rx_in_valid && (!m_rv || rx_out_ready);
    if (m_tv && tx_out_ready && m_tq.size() > 0) void'(m_tq.pop_front());
    if (tfire) begin
      w = {1'b0, tx_in_data};
      c = ones(w);
      if (!par_en) begin w[8] = 0; m_ttag = "R5"; end
      else if (tx_mode == 2'b00) begin w[8] = (c % 2 == 0); m_ttag = "R2"; end
      else if (tx_mode == 2'b10) begin w[8] = (c % 2 == 1); m_ttag = "R3"; end
      else begin w[8] = tx_mode[1]; m_ttag = "R4"; end
      m_tv = 1; m_tw = w; m_thold = 0; m_tq.push_back(int'(w));
    end else if (tx_out_ready) m_tv = 0;
    else if (m_tv) m_thold++;
    if (rfire && rx_gate_en && rts) begin
      m_rv = 0; m_rtag = "R10";
    end else if (rfire) begin
      m_rv = 1;
      m_rd = rx_in_word[7:0];
      c = ones(rx_in_word);
      if (!par_en) begin m_re = 0; m_rtag = "R5"; end
      else if (rx_mode == 2'b00) begin m_re = (c % 2 == 0); m_rtag = "R6"; end
      else if (rx_mode == 2'b10) begin m_re = (c % 2 == 1); m_rtag = "R6"; end
      else begin m_re = (rx_in_word[8] != rx_mode[1]); m_rtag = "R7"; end
    end else if (rx_out_ready) m_rv = 0;
  endtask

  task automatic drive(input int cyc);
    int ph = cyc / 500;
    int rdy_pct = (ph % 2 == 0) ? 80 : 25;
    rst = (cyc < 3) || (cyc >= 2000 && cyc < 2002);
    if (!tx_in_valid || tx_in_ready) begin
      tx_in_valid = ($urandom_range(99) < 70);
      tx_in_data  = 8'($urandom);
    end
    if (!rx_in_valid || rx_in_ready) begin
      rx_in_valid = ($urandom_range(99) < 70);
      rx_in_word  = 9'($urandom);
    end
    tx_out_ready = ($urandom_range(99) < rdy_pct);
    rx_out_ready = ($urandom_range(99) < rdy_pct);
    tx_mode = 2'($urandom);
    rx_mode = 2'($urandom);
    par_en = (ph == 2) ? 1'b0 : (ph == 3) ? 1'($urandom) : 1'b1;
    rx_gate_en = (ph >= 4) ? 1'b1 : (ph == 1) ? 1'($urandom) : 1'b0;
    rts = 1'($urandom);
  endtask

  initial begin
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      @(negedge clk);
      compare();
      drive(cyc);
      model_update();
    end
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule